// File: doc/BRIEF.md
# Tune and Seek Command Sequencer

This block runs the frequency commands of a radio receiver's control logic. Software reaches it through a one-cycle register write port. It first stores the low half of a 16-bit target. It then writes the high half, and that write starts a command. A search configuration register picks the command. A direct tune moves the 10-bit tune position straight to the target. A search moves the position in steps of 1, 2 or 4 units, where one unit is 50 kHz. The search continues until the measured field strength reaches a threshold, or until it runs into the limit given by the target.

Each position the block sets must settle before it is judged. The block raises a measurement request, and the analog side answers with a settle acknowledge and a 3-bit field-strength level. The block reports its result in four ways: a 3-bit result code, a tuned flag, a one-cycle completion pulse for the interrupt logic, and the current tune position. Software can cancel a running command, and removing radio power also ends it.

Top module: `tune_seq_top`

## Requirements
- R1: After reset the result code is 1, the tuned flag is 0, the tune position is 0, and neither the completion pulse nor the measurement request is asserted.
- R2: A write to address 1Eh only stores the low target byte. A write to address 1Fh starts a command with target {1Fh data, 1Eh data}, but only while radio power is on and no command is running. Otherwise the write changes nothing.
- R3: The result code reads 7 for as long as a command is running. The measurement request is high only while the block waits for a settle acknowledge.
- R4: Bits 7:6 of the search configuration register (address 1Dh) hold the step grid. Grid 0 is a direct tune. The position becomes target bits 9:0 on the cycle after launch, and the command ends with code 0 on the next settle acknowledge. If any of target bits 15:10 is set, a direct tune ends at once with code 3 and the position does not move.
- R5: Grids 1, 2 and 3 start a search with steps of 1, 2 and 4 position units. Target bit 14 gives the direction (1 means downward), and target bits 9:0 are the limit. The search takes its first step before it makes its first measurement.
- R6: A search stops on a position once the field-strength level sampled with its settle acknowledge is at least the threshold. The threshold is bits 3:1 of register 1Dh, plus one when bit 0 is set. The command then ends with code 0, and the position stays on that station.
- R7: If the next step would pass beyond the limit, the search ends with code 2 and the position stays at the last position tried.
- R8: If the next step would leave the range 0 to 1023, the search ends with code 3 and the position does not move.
- R9: A write to address 00h while a command is running ends it with code 6. The same write has no effect when the block is idle.
- R10: The tuned flag sets only on a code-0 end. It clears one cycle after radio power goes low, and it clears when a new command starts. A loss of power during a command ends that command with code 6.
- R11: Every end of a command, whether it succeeds, fails or is cancelled, produces exactly one completion pulse one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on | input | 1 | Radio power enable |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| settle_ack | input | 1 | Frequency has settled; field strength is valid |
| fs_level | input | 3 | Measured field-strength level |
| tune_pos | output | 10 | Current tune position |
| status_code | output | 3 | Result code: 0 ok, 1 reset, 2 band limit, 3 range limit, 6 cancelled, 7 busy |
| tuned | output | 1 | Station tuned or found |
| done_pulse | output | 1 | One-cycle completion pulse |
| meas_req | output | 1 | Waiting for a settle acknowledge |

## Verification
The assertions assume two things about the inputs. Register writes are single-cycle strobes. The settle acknowledge and the field-strength level carry meaning only in a cycle where the measurement request is high. The stimulus drives the acknowledge only as a copy of the request seen half a cycle earlier, and it computes the level from a model station at one position. It spaces writes at least one cycle apart, and it changes power only between commands or to cut one short on purpose. Under these conditions the assertions check four relations: the busy code and the request agree, a completion never reports busy, a cancel always produces code 6 with a pulse, and the tuned flag agrees with both the code and power.

// File: rtl/tune_seq_pkg.sv
package tune_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_STEP   = 2'd1,
      ST_SETTLE = 2'd2
   } seq_state_t;

   localparam int GRID_W = 2;
   localparam int THR_W  = 3;

   localparam logic [2:0] CODE_OK    = 3'd0;
   localparam logic [2:0] CODE_RESET = 3'd1;
   localparam logic [2:0] CODE_BAND  = 3'd2;
   localparam logic [2:0] CODE_DAC   = 3'd3;
   localparam logic [2:0] CODE_ABORT = 3'd6;
   localparam logic [2:0] CODE_BUSY  = 3'd7;

   typedef struct packed {
      logic [GRID_W-1:0] grid;
      logic [THR_W-1:0]  thr;
      logic              plus5;
   } scan_cfg_t;

endpackage

// File: rtl/tseq_regs.sv
module tseq_regs
   import tune_seq_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter logic [ADDR_W-1:0] A_ABORT = 8'h00,
   parameter logic [ADDR_W-1:0] A_SCAN  = 8'h1D,
   parameter logic [ADDR_W-1:0] A_TLO   = 8'h1E,
   parameter logic [ADDR_W-1:0] A_THI   = 8'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] tgt_lo_q,
   output scan_cfg_t         scan_q,
   output logic              hi_wr,
   output logic              abort_wr
);

   assign hi_wr    = wr_en && (wr_addr == A_THI);
   assign abort_wr = wr_en && (wr_addr == A_ABORT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_lo_q <= '0;
         scan_q   <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_TLO) tgt_lo_q <= wr_data;
         if (wr_addr == A_SCAN) begin
            scan_q.grid  <= wr_data[DATA_W-1 -: GRID_W];
            scan_q.thr   <= wr_data[THR_W:1];
            scan_q.plus5 <= wr_data[0];
         end
      end
   end

endmodule

// File: rtl/tseq_stepper.sv
module tseq_stepper
   import tune_seq_pkg::*;
#(
   parameter int POS_W = 10
) (
   input  logic [POS_W-1:0]  pos,
   input  logic [GRID_W-1:0] grid,
   input  logic              down,
   input  logic [POS_W-1:0]  limit,
   output logic [POS_W-1:0]  next_pos,
   output logic              dac_err,
   output logic              band_err
);

   localparam int NGRID = 1 << GRID_W;

   logic [POS_W-1:0] step_tab [NGRID];

   for (genvar g = 0; g < NGRID; g++) begin : g_step
      if (g == 0) begin : g_zero
         assign step_tab[g] = '0;
      end else begin : g_pow
         assign step_tab[g] = POS_W'(1) << (g - 1);
      end
   end

   logic [POS_W-1:0] step;
   logic [POS_W:0]   sum;

   assign step = step_tab[grid];

   always_comb begin
      if (down) begin
         sum      = {1'b0, pos} - {1'b0, step};
         dac_err  = pos < step;
         next_pos = sum[POS_W-1:0];
         band_err = !dac_err && (next_pos < limit);
      end else begin
         sum      = {1'b0, pos} + {1'b0, step};
         dac_err  = sum[POS_W];
         next_pos = sum[POS_W-1:0];
         band_err = !dac_err && (next_pos > limit);
      end
   end

endmodule

// File: rtl/tseq_ctrl.sv
module tseq_ctrl
   import tune_seq_pkg::*;
#(
   parameter int POS_W = 10,
   parameter int TGT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_on,
   input  logic              hi_wr,
   input  logic              abort_wr,
   input  logic [TGT_W-1:0]  target,
   input  scan_cfg_t         scan,
   input  logic              settle_ack,
   input  logic [THR_W-1:0]  fs_level,
   input  logic [POS_W-1:0]  next_pos,
   input  logic              dac_err,
   input  logic              band_err,
   output logic [POS_W-1:0]  pos_q,
   output logic [GRID_W-1:0] grid_q,
   output logic              down_q,
   output logic [POS_W-1:0]  limit_q,
   output logic [2:0]        status_q,
   output logic              tuned_q,
   output logic              done_q,
   output logic              meas_req
);

   localparam int DIR_BIT = TGT_W - 2;

   seq_state_t       state_q;
   logic [THR_W-1:0] thr_q;
   logic             plus5_q;
   logic             hit;

   assign hit      = {1'b0, fs_level} >= ({1'b0, thr_q} + {{THR_W{1'b0}}, plus5_q});
   assign meas_req = (state_q == ST_SETTLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         pos_q    <= '0;
         grid_q   <= '0;
         down_q   <= 1'b0;
         limit_q  <= '0;
         thr_q    <= '0;
         plus5_q  <= 1'b0;
         status_q <= CODE_RESET;
         tuned_q  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (state_q != ST_IDLE && (abort_wr || !pwr_on)) begin
            status_q <= CODE_ABORT;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (hi_wr && pwr_on) begin
                     tuned_q <= 1'b0;
                     grid_q  <= scan.grid;
                     thr_q   <= scan.thr;
                     plus5_q <= scan.plus5;
                     down_q  <= target[DIR_BIT];
                     limit_q <= target[POS_W-1:0];
                     if (scan.grid != '0) begin
                        status_q <= CODE_BUSY;
                        state_q  <= ST_STEP;
                     end else if (|target[TGT_W-1:POS_W]) begin
                        status_q <= CODE_DAC;
                        done_q   <= 1'b1;
                     end else begin
                        pos_q    <= target[POS_W-1:0];
                        status_q <= CODE_BUSY;
                        state_q  <= ST_SETTLE;
                     end
                  end
               end
               ST_STEP: begin
                  if (dac_err) begin
                     status_q <= CODE_DAC;
                     done_q   <= 1'b1;
                     state_q  <= ST_IDLE;
                  end else if (band_err) begin
                     status_q <= CODE_BAND;
                     done_q   <= 1'b1;
                     state_q  <= ST_IDLE;
                  end else begin
                     pos_q   <= next_pos;
                     state_q <= ST_SETTLE;
                  end
               end
               ST_SETTLE: begin
                  if (settle_ack) begin
                     if (grid_q == '0 || hit) begin
                        status_q <= CODE_OK;
                        tuned_q  <= 1'b1;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                     end else begin
                        state_q <= ST_STEP;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
         if (!pwr_on) tuned_q <= 1'b0;
      end
   end

   // R3
   busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meas_req |-> status_q == CODE_BUSY);

   // R11
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> status_q != CODE_BUSY);

   // R9
   abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_wr && state_q != ST_IDLE) |=> (status_q == CODE_ABORT && done_q));

   // R10
   pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |=> !tuned_q);

   // R6
   tuned_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tuned_q |-> status_q == CODE_OK);

endmodule

// File: rtl/tune_seq_top.sv
module tune_seq_top
   import tune_seq_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int POS_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_on,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              settle_ack,
   input  logic [2:0]        fs_level,
   output logic [POS_W-1:0]  tune_pos,
   output logic [2:0]        status_code,
   output logic              tuned,
   output logic              done_pulse,
   output logic              meas_req
);

   localparam int TGT_W = 2 * DATA_W;

   if (POS_W <= DATA_W || POS_W > TGT_W - 2) begin : g_bad_pos
      $error("tune_seq_top: POS_W must exceed DATA_W and leave two target bits free");
   end
   if (THR_W != 3) begin : g_bad_thr
      $error("tune_seq_top: threshold field must be 3 bits");
   end

   logic [DATA_W-1:0] tgt_lo;
   scan_cfg_t         scan;
   logic              hi_wr, abort_wr;
   logic [POS_W-1:0]  next_pos, limit;
   logic [GRID_W-1:0] grid;
   logic              down, dac_err, band_err;

   tseq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .tgt_lo_q (tgt_lo),
      .scan_q   (scan),
      .hi_wr    (hi_wr),
      .abort_wr (abort_wr)
   );

   tseq_stepper #(.POS_W(POS_W)) u_step (
      .pos      (tune_pos),
      .grid     (grid),
      .down     (down),
      .limit    (limit),
      .next_pos (next_pos),
      .dac_err  (dac_err),
      .band_err (band_err)
   );

   tseq_ctrl #(.POS_W(POS_W), .TGT_W(TGT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_on     (pwr_on),
      .hi_wr      (hi_wr),
      .abort_wr   (abort_wr),
      .target     ({wr_data, tgt_lo}),
      .scan       (scan),
      .settle_ack (settle_ack),
      .fs_level   (fs_level),
      .next_pos   (next_pos),
      .dac_err    (dac_err),
      .band_err   (band_err),
      .pos_q      (tune_pos),
      .grid_q     (grid),
      .down_q     (down),
      .limit_q    (limit),
      .status_q   (status_code),
      .tuned_q    (tuned),
      .done_q     (done_pulse),
      .meas_req   (meas_req)
   );

endmodule

// File: tb/tune_seq_top_bench.sv
module tune_seq_top_bench;

   typedef struct packed {
      logic [9:0] start;
      logic [1:0] grid;
      logic       down;
      logic [9:0] limit;
      logic [2:0] thr;
      logic       p5;
      logic [9:0] stn;
      logic [2:0] sfs;
      logic [2:0] code;
      logic [9:0] pos;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{10'd100,  2'd2, 1'b0, 10'd200,  3'd3, 1'b0, 10'd110, 3'd3, 3'd0, 10'd110},
      '{10'd100,  2'd1, 1'b0, 10'd105,  3'd3, 1'b0, 10'd300, 3'd7, 3'd2, 10'd105},
      '{10'd500,  2'd3, 1'b1, 10'd400,  3'd4, 1'b1, 10'd480, 3'd4, 3'd2, 10'd400},
      '{10'd500,  2'd3, 1'b1, 10'd400,  3'd4, 1'b1, 10'd480, 3'd5, 3'd0, 10'd480},
      '{10'd1020, 2'd3, 1'b0, 10'd1023, 3'd3, 1'b0, 10'd0,   3'd7, 3'd3, 10'd1020},
      '{10'd2,    2'd3, 1'b1, 10'd0,    3'd3, 1'b0, 10'd900, 3'd7, 3'd3, 10'd2},
      '{10'd10,   2'd2, 1'b0, 10'd10,   3'd3, 1'b0, 10'd900, 3'd7, 3'd2, 10'd10},
      '{10'd50,   2'd1, 1'b1, 10'd40,   3'd2, 1'b0, 10'd47,  3'd7, 3'd0, 10'd47}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_on = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       settle_ack = 1'b0;
   logic [2:0] fs_level = '0;
   logic [9:0] tune_pos;
   logic [2:0] status_code;
   logic       tuned, done_pulse, meas_req;

   int   n_chk = 0;
   int   n_fail = 0;
   logic auto_ack = 1'b1;
   logic [9:0] stn_pos = '0;
   logic [2:0] stn_fs = '0;

   always #10 clk = ~clk;

   tune_seq_top u_tune_seq_top (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .settle_ack(settle_ack),
      .fs_level(fs_level), .tune_pos(tune_pos), .status_code(status_code),
      .tuned(tuned), .done_pulse(done_pulse), .meas_req(meas_req)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_done();
      logic got = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         if (done_pulse) begin
            got = 1'b1;
            break;
         end
         settle_ack = auto_ack && meas_req;
         fs_level   = (tune_pos == stn_pos) ? stn_fs : 3'd0;
         @(negedge clk);
      end
      settle_ack = 1'b0;
      chk(got, "R11 completion pulse seen", got, 1);
      @(negedge clk);
      chk(!done_pulse, "R11 pulse one cycle wide", done_pulse, 0);
   endtask

   task automatic tune_to(input logic [9:0] p);
      wr(8'h1D, 8'h00);
      wr(8'h1E, p[7:0]);
      wr(8'h1F, {6'd0, p[9:8]});
      wait_done();
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(status_code == 3'd1, "R1 reset code", status_code, 1);
      chk(!tuned && tune_pos == 0, "R1 tuned/pos", {tuned, tune_pos}, 0);
      chk(!done_pulse && !meas_req, "R1 pulse/req", {done_pulse, meas_req}, 0);

      // R2 low byte alone launches nothing; power off blocks launch
      pwr_on = 1'b1;
      wr(8'h1E, 8'h55);
      @(negedge clk);
      chk(status_code == 3'd1 && !meas_req, "R2 low byte no launch", status_code, 1);
      pwr_on = 1'b0;
      wr(8'h1F, 8'h00);
      @(negedge clk);
      chk(status_code == 3'd1 && !meas_req, "R2 launch ignored power off", status_code, 1);
      pwr_on = 1'b1;

      // R3 R4 direct tune
      auto_ack = 1'b0;
      wr(8'h1D, 8'h00);
      wr(8'h1E, 8'h2C);
      wr(8'h1F, 8'h01);
      chk(status_code == 3'd7, "R3 busy code", status_code, 7);
      chk(meas_req == 1'b1, "R3 request while settling", meas_req, 1);
      chk(tune_pos == 10'd300, "R4 direct position", tune_pos, 300);
      auto_ack = 1'b1;
      wait_done();
      chk(status_code == 3'd0 && tuned, "R4 direct tune ok", status_code, 0);

      // R4 R10 direct tune out of range
      wr(8'h1E, 8'h2C);
      wr(8'h1F, 8'h04);
      wait_done();
      chk(status_code == 3'd3, "R4 direct range code", status_code, 3);
      chk(tune_pos == 10'd300, "R4 direct range no move", tune_pos, 300);
      chk(!tuned, "R10 tuned cleared by new command", tuned, 0);

      // R5 R6 R7 R8 vector walk
      for (int v = 0; v < NV; v++) begin
         stn_pos = VECS[v].stn;
         stn_fs  = VECS[v].sfs;
         tune_to(VECS[v].start);
         wr(8'h1D, {VECS[v].grid, 2'b00, VECS[v].thr, VECS[v].p5});
         wr(8'h1E, VECS[v].limit[7:0]);
         wr(8'h1F, {1'b0, VECS[v].down, 4'b0000, VECS[v].limit[9:8]});
         wait_done();
         chk(status_code == VECS[v].code, "R5-search code (R6 R7 R8)", status_code, VECS[v].code);
         chk(tune_pos == VECS[v].pos, "R5 search end position", tune_pos, VECS[v].pos);
         chk(tuned == (VECS[v].code == 3'd0), "R6 tuned after search", tuned, VECS[v].code == 3'd0);
      end

      // R9 cancel while busy
      stn_pos = 10'd1000;
      auto_ack = 1'b0;
      wr(8'h1D, 8'h80);
      wr(8'h1E, 8'hFF);
      wr(8'h1F, 8'h03);
      repeat (2) @(negedge clk);
      chk(meas_req && !tuned, "R10 new search clears tuned", tuned, 0);
      wr(8'h00, 8'h00);
      wait_done();
      chk(status_code == 3'd6, "R9 cancel code", status_code, 6);
      wr(8'h00, 8'h00);
      repeat (2) begin
         @(negedge clk);
         chk(status_code == 3'd6 && !done_pulse, "R9 idle cancel ignored", status_code, 6);
      end

      // R10 power loss
      auto_ack = 1'b1;
      tune_to(10'd200);
      chk(tuned, "R10 tuned set", tuned, 1);
      pwr_on = 1'b0;
      @(negedge clk);
      chk(!tuned, "R10 power off clears tuned", tuned, 0);
      pwr_on = 1'b1;
      auto_ack = 1'b0;
      wr(8'h1E, 8'h10);
      wr(8'h1F, 8'h00);
      pwr_on = 1'b0;
      wait_done();
      chk(status_code == 3'd6, "R10 power loss ends command", status_code, 6);

      finish_up();
   end

endmodule